// File: doc/BRIEF.md
# Serial flash status and write-protect register

This block holds the status byte of a serial NOR flash model and decides which memory writes may proceed. A command decoder ahead of it delivers single-cycle strobes for write enable, write disable, status read, status write (with a data byte), page program, sector erase, block erase and chip erase. The block keeps the write-enable latch, the busy flag and the non-volatile protection fields. It grants or refuses each program/erase request and tracks the busy period until the program/erase engine reports completion.

A small two-state sequencer sits at the centre. In state `ST_READY` the device accepts any command. The transition `ACCEPT` (an allowed program or erase) moves it to `ST_ENGINE`. There, only status reads are honoured, until the transition `FINISH` (engine completion strobe) or `ABORT` (soft reset) brings it back to `ST_READY`. A separate combinational port answers, for any address, whether it lies in the protected region. The array is 512 KB, split into eight 64 KB blocks.

The protection fields survive a soft reset. Only the power-on reset reloads them.

Top module: `nor_status_guard`

## Requirements
- R1: The status byte is laid out as bit0 busy, bit1 write-enable latch, bits 4:2 protect level BP (bit2 = BP LSB), bit5 bottom-select TB, bit6 always 0, bit7 lock BPL.
- R2: After power-on reset the status byte reads 0x1C (BP=7, all other bits 0).
- R3: A write-enable strobe sets the latch and a write-disable strobe clears it, one cycle later. In `ST_ENGINE` both are ignored.
- R4: A status write is taken only when the latch is 1 and the device is not busy. It changes only bits 2, 3, 4, 5 and 7, and it clears the latch.
- R5: While BPL is 1, a status write leaves BP and TB unchanged; BPL itself is still written.
- R6: While the write-protect pin is low, a status write leaves TB unchanged; BP and BPL are still written.
- R7: A program or erase strobe while the latch is 0 produces no grant, and busy stays 0.
- R8: An accepted program/erase gives a one-cycle grant in the cycle after the strobe, with mem_op 0 = page program, 1 = sector erase, 2 = block erase, 3 = chip erase. Busy is 1 from that cycle until the cycle after the completion strobe. In that cycle busy and the latch are both 0.
- R9: A page program, sector erase or block erase whose address is protected is refused. A chip erase is refused whenever BP is not 0. A refusal gives no grant and clears the latch.
- R10: query_prot is 1 when: BP=7; or BP in 1..6 and address block addr[18:16] lies among the top min(2^(BP-1),8) blocks (TB=0) or the bottom ones (TB=1). With BP=0 it is 0.
- R11: A soft reset clears busy and the latch in the next cycle and keeps BP, TB and BPL.
- R12: A status-read strobe raises rd_valid in the next cycle, with rd_data equal to the status byte seen in the strobe cycle. This also happens in `ST_ENGINE`.
- R13: When several command strobes coincide, only one is taken, by priority: write disable, write enable, status write, page program, sector erase, block erase, chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_rdsr | input | 1 | Status-read command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_pp | input | 1 | Page-program request strobe |
| cmd_se | input | 1 | Sector-erase request strobe |
| cmd_be | input | 1 | Block-erase request strobe |
| cmd_ce | input | 1 | Chip-erase request strobe |
| cmd_addr | input | 19 | Target address of program/erase |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| eng_done | input | 1 | Completion strobe from the program/erase engine |
| query_addr | input | 19 | Address to test for protection |
| status | output | 8 | Live status byte |
| rd_valid | output | 1 | Status-read response valid |
| rd_data | output | 8 | Status-read response byte |
| mem_grant | output | 1 | One-cycle grant of a program/erase |
| mem_op | output | 2 | Operation of the grant |
| query_prot | output | 1 | query_addr lies in the protected region |

## Verification
The bench targets these traps:
- The lock and the write-protect pin gate different fields. A design that merged them would freeze BP under a low pin, or let TB change under the lock.
- A refusal for protection must still drop the latch, while a refusal for a clear latch leaves nothing to drop. A design that kept the latch after a protected hit would accept a second attempt at a now-unprotected address without a new write enable.
- The decode's boundary blocks are probed at both ends, and BP values 4 to 6 must saturate to the whole array. A design that shifted without a cap would lose protection.
- Commands arriving while busy, soft resets during a busy period, and coinciding strobes are driven both by direct sequences and by a long random phase. Each case would show as a stray grant or latch change against the cycle model.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

    // Status byte bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_BPLO = 2;
    localparam int SB_TB   = 5;
    localparam int SB_RSVD = 6;
    localparam int SB_LOCK = 7;

    // Protect level: all-protected code
    localparam logic [2:0] BP_ALL = 3'd7;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } mem_op_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRDI,
        CMD_WREN,
        CMD_WRSR,
        CMD_MEM
    } cmd_kind_e;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_ENGINE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/nsg_cmd_pick.sv
module nsg_cmd_pick
    import nsg_pkg::*;
(
    input  logic      wrdi,
    input  logic      wren,
    input  logic      wrsr,
    input  logic      pp,
    input  logic      se,
    input  logic      be,
    input  logic      ce,
    output cmd_kind_e kind,
    output mem_op_e   op
);

    // Fixed priority among coinciding strobes (R13)
    always_comb begin
        kind = CMD_NONE;
        op   = OP_PROG;
        if (wrdi) begin
            kind = CMD_WRDI;
        end else if (wren) begin
            kind = CMD_WREN;
        end else if (wrsr) begin
            kind = CMD_WRSR;
        end else if (pp) begin
            kind = CMD_MEM;
            op   = OP_PROG;
        end else if (se) begin
            kind = CMD_MEM;
            op   = OP_SECT;
        end else if (be) begin
            kind = CMD_MEM;
            op   = OP_BLK;
        end else if (ce) begin
            kind = CMD_MEM;
            op   = OP_CHIP;
        end
    end

endmodule

// File: rtl/nsg_region.sv
module nsg_region #(
    parameter int ADDR_W = 19,
    parameter int BLK_W  = 3
) (
    input  logic [2:0]        bp,
    input  logic              tb,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [BLK_W:0] TOTAL_BLK = (BLK_W+1)'(1) << BLK_W;

    logic [BLK_W-1:0] blk;
    logic [BLK_W:0]   nblk;

    assign blk = addr[ADDR_W-1 -: BLK_W];

    // Number of protected blocks, saturating at the whole array
    always_comb begin
        if (bp == 3'd0) begin
            nblk = '0;
        end else if (bp == nsg_pkg::BP_ALL || (int'(bp) - 1) >= BLK_W) begin
            nblk = TOTAL_BLK;
        end else begin
            nblk = (BLK_W+1)'(1) << (bp - 3'd1);
        end
    end

    always_comb begin
        if (tb) begin
            hit = ({1'b0, blk} < nblk);
        end else begin
            hit = ({1'b0, blk} >= (TOTAL_BLK - nblk));
        end
    end

endmodule

// File: rtl/nsg_seq.sv
module nsg_seq
    import nsg_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       soft_rst,
    input  cmd_kind_e  kind,
    input  mem_op_e    op,
    input  logic [7:0] wr_data,
    input  logic       wp_n,
    input  logic       eng_done,
    input  logic       cmd_hit,
    input  logic       rdsr,
    output logic [2:0] bp,
    output logic       tb,
    output logic       bpl,
    output logic       wel,
    output logic       busy,
    output logic       grant,
    output mem_op_e    grant_op,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    seq_state_e state_q, state_d;
    logic       deny;
    logic       accept;
    logic       sr_take;
    logic [7:0] cur_status;

    assign busy = (state_q == ST_ENGINE);

    // Chip erase needs an empty protect field; others test their address
    assign deny    = (op == OP_CHIP) ? (bp != 3'd0) : cmd_hit;
    assign accept  = (state_q == ST_READY) && (kind == CMD_MEM) && wel && !deny;
    assign sr_take = (state_q == ST_READY) && (kind == CMD_WRSR) && wel && !soft_rst;

    assign cur_status = {bpl, 1'b0, tb, bp, wel, busy};

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ACCEPT, FINISH, ABORT
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_READY;
        end else begin
            unique case (state_q)
                ST_READY: begin
                    if (accept) state_d = ST_ENGINE;
                end
                ST_ENGINE: begin
                    if (eng_done) state_d = ST_READY;
                end
            endcase
        end
    end

    // Write-enable latch
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wel <= 1'b0;
        end else if (soft_rst) begin
            wel <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ENGINE: begin
                    if (eng_done) wel <= 1'b0;
                end
                ST_READY: begin
                    unique case (kind)
                        CMD_WRDI: wel <= 1'b0;
                        CMD_WREN: wel <= 1'b1;
                        CMD_WRSR: wel <= 1'b0;
                        CMD_MEM:  if (deny) wel <= 1'b0;
                        default:  wel <= wel;
                    endcase
                end
            endcase
        end
    end

    // Non-volatile protection fields: only power-on reloads them
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bp  <= BP_ALL;
            tb  <= 1'b0;
            bpl <= 1'b0;
        end else if (sr_take) begin
            bpl <= wr_data[SB_LOCK];
            if (!bpl) begin
                bp <= wr_data[SB_BPLO +: 3];
                if (wp_n) tb <= wr_data[SB_TB];
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            grant    <= 1'b0;
            grant_op <= OP_PROG;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            grant    <= accept && !soft_rst;
            if (accept) grant_op <= op;
            rd_valid <= rdsr;
            if (rdsr) rd_data <= cur_status;
        end
    end

endmodule

// File: rtl/nor_status_guard.sv
module nor_status_guard
    import nsg_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_rdsr,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    input  logic              eng_done,
    input  logic [ADDR_W-1:0] query_addr,
    output logic [7:0]        status,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              mem_grant,
    output logic [1:0]        mem_op,
    output logic              query_prot
);

    cmd_kind_e  kind;
    mem_op_e    op;
    mem_op_e    grant_op;
    logic [2:0] bp;
    logic       tb;
    logic       bpl;
    logic       wel;
    logic       busy;
    logic       cmd_hit;

    nsg_cmd_pick u_pick (
        .wrdi (cmd_wrdi),
        .wren (cmd_wren),
        .wrsr (cmd_wrsr),
        .pp   (cmd_pp),
        .se   (cmd_se),
        .be   (cmd_be),
        .ce   (cmd_ce),
        .kind (kind),
        .op   (op)
    );

    nsg_region #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_cmd_region (
        .bp   (bp),
        .tb   (tb),
        .addr (cmd_addr),
        .hit  (cmd_hit)
    );

    nsg_region #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_query_region (
        .bp   (bp),
        .tb   (tb),
        .addr (query_addr),
        .hit  (query_prot)
    );

    nsg_seq u_seq (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .kind     (kind),
        .op       (op),
        .wr_data  (wrsr_data),
        .wp_n     (wp_n),
        .eng_done (eng_done),
        .cmd_hit  (cmd_hit),
        .rdsr     (cmd_rdsr),
        .bp       (bp),
        .tb       (tb),
        .bpl      (bpl),
        .wel      (wel),
        .busy     (busy),
        .grant    (mem_grant),
        .grant_op (grant_op),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign status = {bpl, 1'b0, tb, bp, wel, busy};
    assign mem_op = grant_op;

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker (
    input logic       clk,
    input logic       por_n,
    input logic       soft_rst,
    input logic       wp_n,
    input logic       eng_done,
    input logic       cmd_rdsr,
    input logic [7:0] status,
    input logic       mem_grant,
    input logic       rd_valid
);

    AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!por_n)
        status[6] == 1'b0); // R1

    AST_GRANT_HAD_WEL: assert property (@(posedge clk) disable iff (!por_n)
        mem_grant |-> $past(status[1])); // R7

    AST_GRANT_WITH_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        mem_grant |-> status[0]); // R8

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (status[0] && eng_done && !soft_rst) |=> (!status[0] && !status[1])); // R8

    AST_LOCK_HOLDS_BP: assert property (@(posedge clk) disable iff (!por_n)
        $past(status[7]) |-> $stable(status[4:2])); // R5

    AST_PIN_HOLDS_TB: assert property (@(posedge clk) disable iff (!por_n)
        !$past(wp_n) |-> $stable(status[5])); // R6

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (!status[0] && !status[1])); // R11

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!por_n)
        cmd_rdsr |=> rd_valid); // R12

endmodule

bind nor_status_guard nsg_checker u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .soft_rst  (soft_rst),
    .wp_n      (wp_n),
    .eng_done  (eng_done),
    .cmd_rdsr  (cmd_rdsr),
    .status    (status),
    .mem_grant (mem_grant),
    .rd_valid  (rd_valid)
);

// File: tb/nor_status_guard_tb.sv
`timescale 1ns/1ps
module nor_status_guard_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_rdsr = 1'b0, cmd_wrsr = 1'b0;
    logic [7:0]  wrsr_data = '0;
    logic        cmd_pp = 1'b0, cmd_se = 1'b0, cmd_be = 1'b0, cmd_ce = 1'b0;
    logic [18:0] cmd_addr = '0;
    logic        wp_n = 1'b1;
    logic        eng_done = 1'b0;
    logic [18:0] query_addr = '0;
    logic [7:0]  status;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        mem_grant;
    logic [1:0]  mem_op;
    logic        query_prot;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    nor_status_guard u_dut (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
        .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce),
        .cmd_addr(cmd_addr), .wp_n(wp_n), .eng_done(eng_done),
        .query_addr(query_addr), .status(status), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_grant(mem_grant), .mem_op(mem_op),
        .query_prot(query_prot)
    );

    // Behavioural reference state
    int m_bp = 7, m_tb = 0, m_bpl = 0, m_wel = 0, m_busy = 0;
    int m_grant = 0, m_op = 0, m_rdv = 0, m_rdd = 0;

    function automatic int ref_status();
        return m_bpl * 128 + m_tb * 32 + m_bp * 4 + m_wel * 2 + m_busy;
    endfunction

    // Protected-region test in bytes of a 512 KB array
    function automatic int ref_prot(int bp, int tb, int a);
        int size;
        if (bp == 0) size = 0;
        else if (bp >= 4) size = 524288;
        else size = 65536 * (1 << (bp - 1));
        if (tb != 0) return (a < size) ? 1 : 0;
        return (a >= 524288 - size) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!por_n) begin
            m_bp = 7; m_tb = 0; m_bpl = 0; m_wel = 0; m_busy = 0;
            m_grant = 0; m_op = 0; m_rdv = 0; m_rdd = 0;
        end else begin
            int st;
            int is_mem;
            int op;
            st = ref_status();
            m_rdv = cmd_rdsr ? 1 : 0;
            if (cmd_rdsr) m_rdd = st;
            m_grant = 0;
            is_mem = (cmd_pp || cmd_se || cmd_be || cmd_ce) ? 1 : 0;
            op = cmd_pp ? 0 : cmd_se ? 1 : cmd_be ? 2 : 3;
            if (soft_rst) begin
                m_wel = 0; m_busy = 0;
            end else if (m_busy != 0) begin
                if (eng_done) begin m_busy = 0; m_wel = 0; end
            end else if (cmd_wrdi) begin
                m_wel = 0;
            end else if (cmd_wren) begin
                m_wel = 1;
            end else if (cmd_wrsr) begin
                if (m_wel != 0) begin
                    int old_lock;
                    old_lock = m_bpl;
                    m_bpl = wrsr_data[7];
                    if (old_lock == 0) begin
                        m_bp = wrsr_data[4:2];
                        if (wp_n) m_tb = wrsr_data[5];
                    end
                    m_wel = 0;
                end
            end else if (is_mem != 0 && m_wel != 0) begin
                int refused;
                if (op == 3) refused = (m_bp != 0) ? 1 : 0;
                else refused = ref_prot(m_bp, m_tb, int'(cmd_addr));
                if (refused != 0) begin
                    m_wel = 0;
                end else begin
                    m_grant = 1; m_op = op; m_busy = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // Cycle-by-cycle comparison, after both sides have settled
    always @(posedge clk) begin
        #1;
        if (por_n && !done) begin
            chk({cur_req, " status (R1)"}, int'(status), ref_status());
            chk({cur_req, " grant"}, int'(mem_grant), m_grant);
            if (m_grant != 0) chk({cur_req, " mem_op"}, int'(mem_op), m_op);
            chk({cur_req, " rd_valid"}, int'(rd_valid), m_rdv);
            if (m_rdv != 0) chk({cur_req, " rd_data"}, int'(rd_data), m_rdd);
            chk({cur_req, " query_prot"}, int'(query_prot),
                ref_prot(m_bp, m_tb, int'(query_addr)));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        cmd_wren = 0; cmd_wrdi = 0; cmd_rdsr = 0; cmd_wrsr = 0;
        cmd_pp = 0; cmd_se = 0; cmd_be = 0; cmd_ce = 0;
        eng_done = 0; soft_rst = 0;
    endtask

    task automatic wren();
        cmd_wren = 1; tick(); clr();
    endtask

    task automatic set_sr(input logic [7:0] d);
        wren();
        cmd_wrsr = 1; wrsr_data = d; tick(); clr();
    endtask

    initial begin
        clr();
        repeat (3) @(negedge clk);
        por_n = 1;
        tick();
        chk("R2 reset status", int'(status), 32'h1C);
        chk("R2 no grant", int'(mem_grant), 0);

        cur_req = "R7";
        cmd_pp = 1; cmd_addr = 19'h00100; tick(); clr();
        chk("R7 no grant at wel=0", int'(mem_grant), 0);
        chk("R7 busy stays 0", int'(status), 32'h1C);

        cur_req = "R3";
        wren();
        chk("R3 wren sets wel", int'(status), 32'h1E);
        cmd_wrdi = 1; tick(); clr();
        chk("R3 wrdi clears wel", int'(status), 32'h1C);

        cur_req = "R4";
        set_sr(8'h00);
        chk("R4 write bp=0", int'(status), 32'h00);
        set_sr(8'h43);
        chk("R4 bits 6,1,0 not writable", int'(status), 32'h00);
        cmd_wrsr = 1; wrsr_data = 8'h1C; tick(); clr();
        chk("R4 ignored with wel=0", int'(status), 32'h00);

        cur_req = "R10";
        for (int tbv = 0; tbv < 2; tbv++) begin
            for (int bpv = 0; bpv < 8; bpv++) begin
                set_sr(8'((tbv << 5) | (bpv << 2)));
                for (int k = 0; k < 8; k++) begin
                    query_addr = 19'(k * 65536 + ((k % 2 == 0) ? 0 : 65535));
                    #1;
                    chk("R10 decode", int'(query_prot), ref_prot(bpv, tbv, int'(query_addr)));
                    tick();
                end
            end
        end

        cur_req = "R9";
        set_sr(8'h04);
        wren();
        cmd_pp = 1; cmd_addr = 19'h7FF00; tick(); clr();
        chk("R9 protected refused", int'(mem_grant), 0);
        chk("R9 wel cleared", int'(status), 32'h04);
        wren();
        cmd_ce = 1; tick(); clr();
        chk("R9 chip erase refused", int'(mem_grant), 0);
        chk("R9 chip erase wel cleared", int'(status), 32'h04);

        cur_req = "R8";
        wren();
        cmd_se = 1; cmd_addr = 19'h00100; tick(); clr();
        chk("R8 grant", int'(mem_grant), 1);
        chk("R8 op sector", int'(mem_op), 1);
        chk("R8 busy with wel", int'(status), 32'h07);
        tick();
        chk("R8 grant one cycle", int'(mem_grant), 0);
        cmd_wrdi = 1; tick(); clr();
        chk("R3 wrdi ignored while busy", int'(status), 32'h07);
        cmd_rdsr = 1; tick(); clr();
        chk("R12 read while busy valid", int'(rd_valid), 1);
        chk("R12 read while busy data", int'(rd_data), 32'h07);
        eng_done = 1; tick(); clr();
        chk("R8 done clears busy and wel", int'(status), 32'h04);
        set_sr(8'h00);
        wren();
        cmd_ce = 1; tick(); clr();
        chk("R9 chip erase granted at bp=0", int'(mem_grant), 1);
        chk("R8 op chip", int'(mem_op), 3);
        eng_done = 1; tick(); clr();

        cur_req = "R5";
        set_sr(8'h88);
        chk("R5 lock set", int'(status), 32'h88);
        set_sr(8'h3C);
        chk("R5 bp tb held, lock cleared", int'(status), 32'h08);

        cur_req = "R6";
        wp_n = 0;
        set_sr(8'h2C);
        chk("R6 tb held under pin", int'(status), 32'h0C);
        wp_n = 1;

        cur_req = "R11";
        set_sr(8'hA8);
        wren();
        cmd_pp = 1; cmd_addr = 19'h40000; tick(); clr();
        chk("R11 setup busy", int'(status), 32'hAB);
        soft_rst = 1; tick(); clr();
        chk("R11 soft reset keeps fields", int'(status), 32'hA8);

        cur_req = "R12";
        cmd_rdsr = 1; tick(); clr();
        chk("R12 rd_valid", int'(rd_valid), 1);
        chk("R12 rd_data", int'(rd_data), 32'hA8);
        set_sr(8'h28);
        set_sr(8'h00);

        cur_req = "R13";
        cmd_wren = 1; cmd_wrdi = 1; tick(); clr();
        chk("R13 wrdi beats wren", int'(status), 32'h00);
        wren();
        cmd_wrsr = 1; wrsr_data = 8'h10; cmd_pp = 1; cmd_addr = 19'h0; tick(); clr();
        chk("R13 wrsr beats program", int'(mem_grant), 0);
        chk("R13 status after wrsr", int'(status), 32'h10);

        cur_req = "RANDOM";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cmd_wren = (r < 25);
            cmd_wrdi = ($urandom_range(0, 99) < 4);
            cmd_rdsr = ($urandom_range(0, 99) < 20);
            cmd_wrsr = ($urandom_range(0, 99) < 10);
            wrsr_data = 8'($urandom);
            cmd_pp = ($urandom_range(0, 99) < 12);
            cmd_se = ($urandom_range(0, 99) < 6);
            cmd_be = ($urandom_range(0, 99) < 6);
            cmd_ce = ($urandom_range(0, 99) < 4);
            cmd_addr = 19'($urandom);
            query_addr = 19'($urandom);
            wp_n = ($urandom_range(0, 99) < 70);
            eng_done = ($urandom_range(0, 99) < 20);
            soft_rst = ($urandom_range(0, 99) < 2);
            tick();
        end
        clr();
        wp_n = 1;

        cur_req = "R2";
        por_n = 0; tick(); por_n = 1; tick();
        chk("R2 power-on again", int'(status), 32'h1C);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule